// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block sends bytes over a clocked two-wire serial link. It has one clock line and one data line. Software loads bytes through a one-byte holding stage that sits in front of an 8-bit shifter. While one byte is being shifted out, the next one can already be waiting. If software refills the holding stage each time the empty flag rises, consecutive bytes leave with no idle clock periods between them.

The transfer clock comes from one of two places, chosen by the master select input. In master mode the block makes the clock itself by dividing the system clock; a 4-bit rate code sets the divide ratio. In slave mode the block follows an external clock on the clock input pin. In both modes a data bit changes only on a falling transfer-clock edge. The bit count advances on the rising edge, where the receiver samples. Each byte is sent least significant bit first.

Top module: `sertx_top`

## Requirements
- R1: While `enable` is 0, `tx_empty` is 0, `sclk_out` is 1, `sda_out` is 1, no transfer is in progress and no byte is pending.
- R2: A 0-to-1 change of `tx_mode` with `enable` high and no byte pending sets `tx_empty` on the next clock.
- R3: A write accepted while no frame is in progress starts a frame at once and leaves `tx_empty` at 1. A write accepted during a frame is parked in the holding stage and clears `tx_empty`. A parked byte always implies a frame in progress.
- R4: A write is accepted only while `tx_empty` is 1 and `tx_mode` is 1. Any other write has no effect on the bytes sent.
- R5: `sda_out` changes only on a falling transfer-clock edge. Bit 0 is sent first and bit 7 last.
- R6: In master mode, a rate code c gives a transfer clock low and high for c+1 system clocks each, so a period is 2·(c+1). The first rising edge comes 2·(c+1) clocks after the accepting write. The clock rests at 1 whenever no frame is in progress.
- R7: A byte parked during a frame follows directly: the rising-edge spacing stays 2·(c+1) across the byte boundary, and `tx_empty` returns to 1 when the parked byte enters the shifter.
- R8: `sclk_oe` equals `enable AND master`. With `master` at 0, `sclk_out` stays 1 and falling/rising edges of `sclk_in` (after a two-flop synchronizer) time the bits.
- R9: After the last frame, `sda_out` keeps the value of the last bit sent.
- R10: Clearing `tx_mode` clears `tx_empty` and blocks writes. The frame in progress and any parked byte are still sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 forces idle |
| master | input | 1 | 1: drive transfer clock, 0: follow `sclk_in` |
| tx_mode | input | 1 | Transmit mode select |
| clk_sel | input | 4 | Master rate code c, half period c+1 clocks |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| tx_empty | output | 1 | Holding stage can take a byte |
| sclk_out | output | 1 | Transfer clock driven in master mode |
| sclk_oe | output | 1 | Output enable for the transfer clock |
| sclk_in | input | 1 | Transfer clock from the pin in slave mode |
| sda_out | output | 1 | Serial data |

## Verification
The hardest situation to reach is the handover between bytes. The parked byte has to enter the shifter on the same rising edge that ends the previous frame, for every clock ratio. It also has to do so when transmit mode has already been left. The bench sweeps all sixteen rate codes. For each code it writes a second byte immediately after the first, while the shifter is busy, and adds a third write that must be dropped. It timestamps every rising clock edge to confirm the even spacing across the boundary. A separate run clears `tx_mode` while a byte is parked and checks that both frames still complete.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 4;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] hold;
        logic [CNT_W-1:0]  bitcnt;
        logic              busy;
        logic              hold_full;
        logic              empty;
        logic              txm;
        logic              sda;
    } shift_st_t;

    typedef struct packed {
        logic [SEL_W-1:0] cnt;
        logic             sclk;
    } mclk_st_t;
endpackage

// File: rtl/sertx_mclk.sv
module sertx_mclk
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             busy_i,
    output logic             sclk_o,
    output logic             fall_o,
    output logic             rise_o
);
    mclk_st_t st_q, st_d;
    logic     tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run_i) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b1;
        end else if (st_q.cnt == sel_i) begin
            tick      = 1'b1;
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;
    assign fall_o = tick & st_q.sclk;
    assign rise_o = tick & ~st_q.sclk;

    // R6
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> st_q.sclk);
endmodule

// File: rtl/sertx_sync.sv
module sertx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pin_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q, chain_d;

    always_comb begin
        if (!en_i) chain_d = '1;
        else       chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign fall_o = en_i &  chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
    assign rise_o = en_i & ~chain_q[CHAIN_W-1] &  chain_q[CHAIN_W-2];

    // R8
    sync_edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_o && rise_o));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              tx_mode_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fall_i,
    input  logic              rise_i,
    output logic              empty_o,
    output logic              busy_o,
    output logic              sda_o
);
    localparam shift_st_t IDLE = '{shreg: '0, hold: '0, bitcnt: '0, busy: 1'b0,
                                   hold_full: 1'b0, empty: 1'b0, txm: 1'b0, sda: 1'b1};
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    shift_st_t q, d;
    logic done, accept, tx_rise;

    always_comb begin
        d       = q;
        tx_rise = tx_mode_i & ~q.txm;
        d.txm   = tx_mode_i;
        done    = q.busy & rise_i & (q.bitcnt == LAST);
        accept  = wr_i & q.empty & tx_mode_i;

        if (q.busy && fall_i) d.sda = q.shreg[0];
        if (q.busy && rise_i) begin
            d.shreg  = q.shreg >> 1;
            d.bitcnt = q.bitcnt + 1'b1;
        end
        if (done) begin
            if (q.hold_full) begin
                d.shreg     = q.hold;
                d.bitcnt    = '0;
                d.hold_full = 1'b0;
                d.empty     = 1'b1;
            end else begin
                d.busy = 1'b0;
            end
        end
        if (accept) begin
            if (!q.busy || (done && !q.hold_full)) begin
                d.shreg  = wdata_i;
                d.bitcnt = '0;
                d.busy   = 1'b1;
            end else begin
                d.hold      = wdata_i;
                d.hold_full = 1'b1;
                d.empty     = 1'b0;
            end
        end
        if (tx_rise && !d.hold_full) d.empty = 1'b1;
        if (!tx_mode_i) d.empty = 1'b0;
        if (!enable_i) d = IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE;
        else        q <= d;
    end

    assign empty_o = q.empty;
    assign busy_o  = q.busy;
    assign sda_o   = q.sda;

    // R5
    sda_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !fall_i) |=> $stable(q.sda));
    // R3
    parked_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold_full |-> !q.empty);
    // R3
    parked_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold_full |-> q.busy);
    // R2
    mode_entry_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && tx_mode_i && !q.txm && !q.hold_full) |=> q.empty);
    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!q.busy && !q.empty && q.sda));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master,
    input  logic              tx_mode,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sclk_in,
    output logic              sda_out
);
    logic busy, m_fall, m_rise, s_fall, s_rise, fall, rise;
    logic m_run, s_run;

    assign m_run = enable & master & busy;
    assign s_run = enable & ~master;

    sertx_mclk u_mclk (
        .clk(clk), .rst_n(rst_n), .run_i(m_run), .sel_i(clk_sel),
        .busy_i(busy), .sclk_o(sclk_out), .fall_o(m_fall), .rise_o(m_rise)
    );

    sertx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .en_i(s_run), .pin_i(sclk_in),
        .fall_o(s_fall), .rise_o(s_rise)
    );

    assign fall = master ? m_fall : s_fall;
    assign rise = master ? m_rise : s_rise;

    sertx_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .tx_mode_i(tx_mode),
        .wr_i(wr_en), .wdata_i(wr_data), .fall_i(fall), .rise_i(rise),
        .empty_o(tx_empty), .busy_o(busy), .sda_o(sda_out)
    );

    assign sclk_oe = enable & master;

    // R8
    slave_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> sclk_out);
endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, master = 1'b0, tx_mode = 1'b0;
    logic [3:0] clk_sel = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sclk_in = 1'b1;
    logic       tx_empty, sclk_out, sclk_oe, sda_out;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nrise = 0;
    int rise_at [64];
    logic rx_bit [64];
    logic sclk_prev = 1'b1;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .tx_mode(tx_mode),
        .clk_sel(clk_sel), .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sclk_in(sclk_in), .sda_out(sda_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!sclk_prev && sclk_out && nrise < 64) begin
            rise_at[nrise] = cyc;
            rx_bit[nrise]  = sda_out;
            nrise++;
        end
        sclk_prev = sclk_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v, output int stamp);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1 stamp = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_frames(input string req, input logic [7:0] a, input logic [7:0] b);
        chk(nrise == 16, req, nrise, 16);
        for (int i = 0; i < 16; i++) begin
            logic e;
            e = (i < 8) ? a[i] : b[i-8];
            chk(rx_bit[i] == e, req, rx_bit[i], e);
        end
    endtask

    initial begin
        int st, h;
        logic [7:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_empty == 0, "R1", tx_empty, 0);
        chk(sclk_out == 1, "R1", sclk_out, 1);
        chk(sda_out == 1, "R1", sda_out, 1);
        chk(sclk_oe == 0, "R8", sclk_oe, 0);

        for (int c = 0; c < 16; c++) begin
            h = c + 1;
            a = 8'(8'h35 + c * 29);
            b = 8'(8'hC2 ^ (c * 13));
            @(negedge clk);
            enable = 1; master = 1; clk_sel = 4'(c); tx_mode = 0;
            @(negedge clk);
            chk(sclk_oe == 1, "R8", sclk_oe, 1);
            chk(tx_empty == 0, "R10", tx_empty, 0);
            tx_mode = 1;
            @(negedge clk);
            chk(tx_empty == 1, "R2", tx_empty, 1);
            nrise = 0;
            wr(a, st);
            chk(tx_empty == 1, "R3", tx_empty, 1);
            begin
                int s2;
                wr(b, s2);
            end
            chk(tx_empty == 0, "R3", tx_empty, 0);
            begin
                int s3;
                wr(8'hFF ^ b, s3);  // R4 write while full must be dropped
            end
            repeat (34 * h + 8) @(negedge clk);
            check_frames("R5", a, b);
            chk(rise_at[0] - st == 2 * h, "R6", rise_at[0] - st, 2 * h);
            for (int i = 1; i < 16; i++)
                chk(rise_at[i] - rise_at[i-1] == 2 * h, "R7", rise_at[i] - rise_at[i-1], 2 * h);
            chk(tx_empty == 1, "R7", tx_empty, 1);
            chk(sclk_out == 1, "R6", sclk_out, 1);
            chk(sda_out == b[7], "R9", sda_out, b[7]);
            @(negedge clk);
            enable = 0;
            @(negedge clk);
            chk(tx_empty == 0 && sda_out == 1 && sclk_out == 1, "R1",
                {tx_empty, sda_out, sclk_out}, 3'b011);
        end

        // R10: leave transmit mode while a byte is parked
        @(negedge clk);
        enable = 1; master = 1; clk_sel = 4'd2; tx_mode = 1;
        @(negedge clk);
        nrise = 0;
        wr(8'h9B, st);
        begin
            int s2;
            wr(8'h4E, s2);
        end
        @(negedge clk);
        tx_mode = 0;
        @(negedge clk);
        chk(tx_empty == 0, "R10", tx_empty, 0);
        begin
            int s3;
            wr(8'h11, s3);  // R4 write with tx_mode low ignored
        end
        repeat (120) @(negedge clk);
        check_frames("R10", 8'h9B, 8'h4E);
        chk(tx_empty == 0, "R10", tx_empty, 0);

        // R8 slave mode: bits timed by sclk_in
        @(negedge clk);
        enable = 0;
        @(negedge clk);
        enable = 1; master = 0; tx_mode = 1;
        @(negedge clk);
        chk(sclk_oe == 0, "R8", sclk_oe, 0);
        begin
            int s4;
            wr(8'hA6, s4);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sclk_in = 0;
            repeat (5) @(negedge clk);
            chk(sda_out == a_bit(8'hA6, i), "R8", sda_out, a_bit(8'hA6, i));
            chk(sclk_out == 1, "R8", sclk_out, 1);
            sclk_in = 1;
            repeat (5) @(negedge clk);
        end
        chk(sda_out == 1'b1, "R9", sda_out, 1);
        chk(tx_empty == 1, "R3", tx_empty, 1);
        done = 1;
    end

    function automatic logic a_bit(input logic [7:0] v, input int i);
        return v[i];
    endfunction

    initial begin
        while (!done && cyc < 150000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule